// File: doc/BRIEF.md
# Speculative Load Alias Guard

This block lets a scheduler hoist a load above older stores that might write the same bytes. When such a hoisted load issues, it records its destination register, its byte address and its access size in a small table. Every store that follows searches all entries at once. An entry whose byte range intersects the store's range is dropped. Before the hoisted value may be used, a check for the destination register asks whether its entry is still present and valid. A failing answer tells the pipeline to run recovery code.

The table has a parameter-set number of entries, eight by default. A new hoisted load to a register that already owns an entry rewrites that entry. Otherwise the new load takes the lowest-numbered empty slot. When no slot is empty, a round-robin pointer picks the entry to replace, and any later check for the displaced register fails. A check never changes the table. Its answer appears on the response outputs one clock after the request.

Top module: `ld_alias_table`

## Requirements
- R1: After reset every entry is empty, `chk_rsp_valid` is 0, and a check for any register fails.
- R2: After a load is recorded, a check for its register gives `chk_rsp_valid`=1 and `chk_rsp_ok`=1 one cycle after the request.
- R3: A check for a register that was never recorded gives `chk_rsp_ok`=0.
- R4: A store whose byte range [addr, addr+2^size) shares at least one byte with an entry's range empties that entry, including a partial overlap. The size field is the base-2 logarithm of the byte count.
- R5: A store whose range only touches an entry's range (it ends at the entry's first byte, or starts just past its last byte) leaves the entry valid.
- R6: Recording a load to a register that already owns an entry replaces that entry's address and size. Stores to the old range no longer affect it, and stores to the new range do.
- R7: When every entry is valid, a new register replaces entries in round-robin order starting at slot 0. After that, a check for the displaced register fails.
- R8: When a store and a check arrive in the same cycle, the store's invalidation is applied before the check is answered.
- R9: A check does not modify the table. A repeated successful check succeeds again, and a failed check leaves other entries valid.
- R10: While an empty slot exists, a new register fills the lowest empty slot. It evicts nothing and does not advance the replacement pointer.
- R11: `chk_rsp_valid` is 1 exactly in the cycle after a cycle with `chk_valid`=1, and 0 otherwise.
- R12: A load recorded in the same cycle as an overlapping store is kept valid, because the store only acts on entries that already exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Record a hoisted load this cycle |
| ins_reg | input | REG_W | Destination register of the hoisted load |
| ins_addr | input | ADDR_W | Byte address of the hoisted load |
| ins_size | input | SIZE_W | log2 of the load's byte count |
| st_valid | input | 1 | A store is searching the table this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| st_size | input | SIZE_W | log2 of the store's byte count |
| chk_valid | input | 1 | Check request this cycle |
| chk_reg | input | REG_W | Register being checked |
| chk_rsp_valid | output | 1 | Check answer valid (one cycle after the request) |
| chk_rsp_ok | output | 1 | 1 when the speculative value may be used, 0 when recovery is needed |

## Verification
A store search and a check can fall in the same cycle. A store search and a new recording can also coincide. The bench drives a store and a check to the same register's range together and expects a failing answer (R8). As a control, it then pairs a non-overlapping store with a check and expects success. It also drives an overlapping store in the same cycle as a new recording, then checks the new register separately and expects the entry to have survived (R12).

// File: rtl/ldat_pkg.sv
package ldat_pkg;

   typedef enum logic [1:0] {
      PLACE_REUSE = 2'd0,
      PLACE_FREE  = 2'd1,
      PLACE_EVICT = 2'd2
   } place_e;

   // largest shift amount a size field of the given width can encode
   function automatic int unsigned max_span_log2(input int unsigned size_w);
      return (32'd1 << size_w) - 32'd1;
   endfunction

endpackage

// File: rtl/ldat_overlap.sv
module ldat_overlap #(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 2
) (
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [SIZE_W-1:0] a_size,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [SIZE_W-1:0] b_size,
   output logic              hit
);
   localparam int EXT_W = ADDR_W + 1;

   logic [EXT_W-1:0] a_lo, a_hi, b_lo, b_hi;

   // half-open byte ranges; the extra bit keeps the top of the space from wrapping
   always_comb begin
      a_lo = {1'b0, a_addr};
      b_lo = {1'b0, b_addr};
      a_hi = a_lo + (EXT_W'(1) << a_size);
      b_hi = b_lo + (EXT_W'(1) << b_size);
      hit  = (a_lo < b_hi) && (b_lo < a_hi);
   end

endmodule

// File: rtl/ldat_place.sv
module ldat_place
   import ldat_pkg::*;
#(
   parameter int ENTRIES   = 8,
   parameter bit FILL_FREE = 1'b1,
   localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ins_valid,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [ENTRIES-1:0] reuse_vec,
   output logic [ENTRIES-1:0] wr_sel,
   output logic               evict
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0] rr_ptr;
   logic [IDX_W-1:0] pick;
   logic [IDX_W-1:0] reuse_idx;
   logic [IDX_W-1:0] free_idx;
   logic             free_found;
   place_e           kind;

   always_comb begin
      reuse_idx = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (reuse_vec[i]) reuse_idx = IDX_W'(i);
   end

   generate
      if (FILL_FREE) begin : g_fill
         always_comb begin
            free_found = 1'b0;
            free_idx   = '0;
            for (int i = ENTRIES - 1; i >= 0; i--)
               if (!valid_vec[i]) begin
                  free_found = 1'b1;
                  free_idx   = IDX_W'(i);
               end
         end
      end else begin : g_rr_only
         assign free_found = 1'b0;
         assign free_idx   = '0;
      end
   endgenerate

   always_comb begin
      if (|reuse_vec) begin
         kind = PLACE_REUSE;
         pick = reuse_idx;
      end else if (free_found) begin
         kind = PLACE_FREE;
         pick = free_idx;
      end else begin
         kind = PLACE_EVICT;
         pick = rr_ptr;
      end
   end

   assign evict = (kind == PLACE_EVICT);

   genvar g;
   generate
      for (g = 0; g < ENTRIES; g++) begin : g_sel
         assign wr_sel[g] = (pick == IDX_W'(g));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rr_ptr <= '0;
      else if (ins_valid && evict)
         rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + IDX_W'(1);
   end

   // R7: replacement advances the pointer by one slot
   a_r7_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && evict && rr_ptr != LAST) |=> (rr_ptr == $past(rr_ptr) + IDX_W'(1)));

   // R7: the pointer wraps back to slot 0
   a_r7_rr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && evict && rr_ptr == LAST) |=> (rr_ptr == '0));

   // R10: filling an empty slot or rewriting an entry leaves the pointer alone
   a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !evict) |=> $stable(rr_ptr));

endmodule

// File: rtl/ld_alias_table.sv
module ld_alias_table
   import ldat_pkg::*;
#(
   parameter int ENTRIES   = 8,
   parameter int ADDR_W    = 32,
   parameter int REG_W     = 7,
   parameter int SIZE_W    = 2,
   parameter bit FILL_FREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_valid,
   input  logic [REG_W-1:0]  ins_reg,
   input  logic [ADDR_W-1:0] ins_addr,
   input  logic [SIZE_W-1:0] ins_size,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [SIZE_W-1:0] st_size,
   input  logic              chk_valid,
   input  logic [REG_W-1:0]  chk_reg,
   output logic              chk_rsp_valid,
   output logic              chk_rsp_ok
);
   initial begin
      a_cfg_entries: assert (ENTRIES >= 2)
         else $error("ENTRIES must be at least 2");
      a_cfg_span: assert (ADDR_W > int'(max_span_log2(SIZE_W)))
         else $error("ADDR_W too small for the largest access size");
      a_cfg_reg: assert (REG_W >= 1)
         else $error("REG_W must be positive");
   end

   logic [ENTRIES-1:0] ent_v;
   logic [REG_W-1:0]   ent_reg  [ENTRIES];
   logic [ADDR_W-1:0]  ent_addr [ENTRIES];
   logic [SIZE_W-1:0]  ent_size [ENTRIES];

   logic [ENTRIES-1:0] ovl;
   logic [ENTRIES-1:0] st_hit;
   logic [ENTRIES-1:0] ins_reg_hit;
   logic [ENTRIES-1:0] chk_reg_hit;
   logic [ENTRIES-1:0] wr_sel;
   logic               evict;
   logic               chk_pass;

   genvar g;
   generate
      for (g = 0; g < ENTRIES; g++) begin : g_ent
         ldat_overlap #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ovl (
            .a_addr (ent_addr[g]),
            .a_size (ent_size[g]),
            .b_addr (st_addr),
            .b_size (st_size),
            .hit    (ovl[g])
         );
         assign st_hit[g]      = st_valid & ent_v[g] & ovl[g];
         assign ins_reg_hit[g] = ent_v[g] & (ent_reg[g] == ins_reg);
         assign chk_reg_hit[g] = ent_v[g] & (ent_reg[g] == chk_reg);

         always_ff @(posedge clk) begin
            if (ins_valid && wr_sel[g]) begin
               ent_reg[g]  <= ins_reg;
               ent_addr[g] <= ins_addr;
               ent_size[g] <= ins_size;
            end
         end

         // R4: an overlapping store empties an entry that is not being rewritten
         a_r4_store_kills: assert property (@(posedge clk) disable iff (!rst_n)
            (st_hit[g] && !(ins_valid && wr_sel[g])) |=> !ent_v[g]);

         // R12: a freshly written entry is valid next cycle regardless of stores
         a_r12_new_survives: assert property (@(posedge clk) disable iff (!rst_n)
            (ins_valid && wr_sel[g]) |=> ent_v[g]);
      end
   endgenerate

   ldat_place #(.ENTRIES(ENTRIES), .FILL_FREE(FILL_FREE)) u_place (
      .clk       (clk),
      .rst_n     (rst_n),
      .ins_valid (ins_valid),
      .valid_vec (ent_v),
      .reuse_vec (ins_reg_hit),
      .wr_sel    (wr_sel),
      .evict     (evict)
   );

   // store first: an entry killed this cycle cannot satisfy the check
   assign chk_pass = |(chk_reg_hit & ~st_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_v <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (ins_valid && wr_sel[i]) ent_v[i] <= 1'b1;
            else if (st_hit[i])         ent_v[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_rsp_valid <= 1'b0;
         chk_rsp_ok    <= 1'b0;
      end else begin
         chk_rsp_valid <= chk_valid;
         chk_rsp_ok    <= chk_valid & chk_pass;
      end
   end

   // R11: an answer follows every request, and only a request
   a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |=> chk_rsp_valid);
   a_r11_rsp_only: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid |=> !chk_rsp_valid);

   // R8: a check whose entry is hit by a same-cycle store fails
   a_r8_store_first: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && |(chk_reg_hit & st_hit)) |=> !chk_rsp_ok);

   // R6: a register owns at most one valid entry
   a_r6_unique_reg: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chk_reg_hit));

endmodule

// File: tb/test_ld_alias_table.sv
module test_ld_alias_table;
   localparam int ENTRIES = 8;
   localparam int ADDR_W  = 32;
   localparam int REG_W   = 7;
   localparam int SIZE_W  = 2;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              ins_valid;
   logic [REG_W-1:0]  ins_reg;
   logic [ADDR_W-1:0] ins_addr;
   logic [SIZE_W-1:0] ins_size;
   logic              st_valid;
   logic [ADDR_W-1:0] st_addr;
   logic [SIZE_W-1:0] st_size;
   logic              chk_valid;
   logic [REG_W-1:0]  chk_reg;
   logic              chk_rsp_valid;
   logic              chk_rsp_ok;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   ld_alias_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .REG_W(REG_W), .SIZE_W(SIZE_W)) i_ld_alias_table (
      .clk, .rst_n, .ins_valid, .ins_reg, .ins_addr, .ins_size,
      .st_valid, .st_addr, .st_size, .chk_valid, .chk_reg,
      .chk_rsp_valid, .chk_rsp_ok
   );

   task automatic expect_bit(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      ins_valid = 0; ins_reg = '0; ins_addr = '0; ins_size = '0;
      st_valid = 0; st_addr = '0; st_size = '0;
      chk_valid = 0; chk_reg = '0;
   endtask

   // inputs are set 1 ns after an edge; outputs are read 1 ns after the next edge
   task automatic step();
      @(posedge clk);
      #1;
      idle_inputs();
   endtask

   task automatic do_reset();
      idle_inputs();
      rst_n = 0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1;
   endtask

   task automatic put_load(input int r, input logic [ADDR_W-1:0] a, input int s);
      ins_valid = 1; ins_reg = REG_W'(r); ins_addr = a; ins_size = SIZE_W'(s);
      step();
   endtask

   task automatic put_store(input logic [ADDR_W-1:0] a, input int s);
      st_valid = 1; st_addr = a; st_size = SIZE_W'(s);
      step();
   endtask

   task automatic probe(input int r, input logic exp_ok, input string req);
      chk_valid = 1; chk_reg = REG_W'(r);
      step();
      expect_bit({req, " rsp_valid"}, chk_rsp_valid, 1'b1);
      expect_bit({req, " rsp_ok"}, chk_rsp_ok, exp_ok);
   endtask

   task automatic t_reset();
      do_reset();
      expect_bit("R1 idle rsp_valid", chk_rsp_valid, 1'b0);
      probe(5, 1'b0, "R1 empty table");
      probe(0, 1'b0, "R1 register 0");
   endtask

   task automatic t_basic();
      put_load(1, 32'h100, 2);
      probe(1, 1'b1, "R2 recorded load");
      probe(1, 1'b1, "R9 repeated check");
      probe(2, 1'b0, "R3 unknown register");
      step();
      expect_bit("R11 no request no answer", chk_rsp_valid, 1'b0);
   endtask

   task automatic t_store_ranges();
      put_store(32'h104, 2);
      probe(1, 1'b1, "R5 store just above");
      put_store(32'h0FC, 2);
      probe(1, 1'b1, "R5 store just below");
      put_store(32'h103, 0);
      probe(1, 1'b0, "R4 one-byte partial overlap");
      probe(1, 1'b0, "R9 failed check repeated");
      put_load(3, 32'h200, 0);
      put_store(32'h1F8, 3);
      probe(3, 1'b1, "R5 wide store below");
      put_store(32'h200, 3);
      probe(3, 1'b0, "R4 wide store covers byte");
   endtask

   task automatic t_rewrite();
      put_load(4, 32'h300, 2);
      put_load(4, 32'h400, 2);
      put_store(32'h300, 2);
      probe(4, 1'b1, "R6 old range ignored");
      put_store(32'h402, 0);
      probe(4, 1'b0, "R6 new range tracked");
   endtask

   task automatic t_same_cycle();
      put_load(5, 32'h500, 2);
      put_load(6, 32'h600, 2);
      st_valid = 1; st_addr = 32'h500; st_size = 2;
      chk_valid = 1; chk_reg = 7'd5;
      step();
      expect_bit("R8 store+check rsp_valid", chk_rsp_valid, 1'b1);
      expect_bit("R8 store applied first", chk_rsp_ok, 1'b0);
      st_valid = 1; st_addr = 32'h680; st_size = 2;
      chk_valid = 1; chk_reg = 7'd6;
      step();
      expect_bit("R8 unrelated store with check", chk_rsp_ok, 1'b1);
      ins_valid = 1; ins_reg = 7'd7; ins_addr = 32'h700; ins_size = 2;
      st_valid = 1; st_addr = 32'h700; st_size = 2;
      step();
      probe(7, 1'b1, "R12 new entry survives same-cycle store");
      probe(6, 1'b1, "R9 other entry kept after failed check");
   endtask

   task automatic t_replace();
      do_reset();
      for (int i = 0; i < ENTRIES; i++) put_load(10 + i, 32'h1000 + 32'(16 * i), 0);
      for (int i = 0; i < ENTRIES; i++) probe(10 + i, 1'b1, "R10 fill empty slots");
      put_load(18, 32'h2000, 0);
      probe(10, 1'b0, "R7 slot 0 replaced first");
      probe(11, 1'b1, "R7 slot 1 still held");
      probe(18, 1'b1, "R7 newcomer present");
      put_load(19, 32'h2010, 0);
      probe(11, 1'b0, "R7 slot 1 replaced second");
      probe(12, 1'b1, "R7 slot 2 still held");
      put_store(32'h1050, 0);
      probe(15, 1'b0, "R4 slot 5 emptied");
      put_load(20, 32'h2020, 0);
      probe(12, 1'b1, "R10 empty slot used, no eviction");
      probe(13, 1'b1, "R10 neighbour kept");
      probe(20, 1'b1, "R10 newcomer present");
      put_load(21, 32'h2030, 0);
      probe(12, 1'b0, "R7 pointer resumed at slot 2");
      probe(13, 1'b1, "R7 slot 3 still held");
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      idle_inputs();
      rst_n = 0;
      t_reset();
      t_basic();
      t_store_ranges();
      t_rewrite();
      t_same_cycle();
      t_replace();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule